// File: doc/BRIEF.md
# Interrupt Mask and Clock-Stretch Timeout Unit

This block holds the interrupt bookkeeping of a two-wire serial bus controller on the register side. Each interrupt source has one sticky status bit and one mask bit. A source's event sets its status bit whether or not the source is masked, so software can always poll it. Software clears status bits by writing ones to them. One interrupt line is driven high whenever a status bit is set and its mask bit allows it.

The mask cannot be written directly. Bits are turned on by writing ones to an enable register and turned off by writing ones to a disable register. The mask itself can only be read.

The same status register also receives a watchdog that looks for clock stretching. While the sampled clock line stays low, the watchdog counts serial-clock period ticks that come from the clock divider. When the count reaches a programmable limit, it raises the timeout status bit. The limit fits in an 8-bit field. It fires at most once for each low period and starts again from zero when the line goes high.

Top module: `irq_mask_timeout`

## Requirements
- R1: A register write to address 2 (enable) sets every mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R2: A register write to address 3 (disable) clears every mask bit whose write-data bit is 1. Bits written as 0 keep their value. Internally, a set and a clear of the same bit in the same cycle give a cleared bit.
- R3: Reading address 1 returns the mask, where 1 means enabled. A write to address 1 changes nothing.
- R4: An event pulse on `evt_in[i]` sets status bit i on that clock edge, whatever the mask holds. Address 0 reads the status.
- R5: Writing 1 to a status bit at address 0 clears it, and writing 0 leaves it unchanged. If an event arrives in the same cycle as the clear, the bit stays set.
- R6: `irq_out` is high exactly when some bit is 1 in both status and mask. It follows the registers with no added cycle.
- R7: Address 4 holds the timeout limit. It is TO_W bits wide, readable and writable.
- R8: While `scl_in` is low, each `scl_tick` pulse adds one to the stretch count, and ticks while the line is high are not counted. The tick that brings the count to the limit sets the timeout status bit on that same edge. With a limit of 255, the 255th tick is the one that sets it.
- R9: The stretch count goes back to zero whenever `scl_in` is high. Timeout is raised at most once for each low period.
- R10: A limit of 0 turns the watchdog off.
- R11: After reset, status and mask are all zeros, `irq_out` is 0, and the limit is all ones (255 for TO_W = 8).
- R12: Status/mask bit 0 belongs to transfer completion and bit NUM_SRC-1 belongs to timeout. Every source uses the same enable, disable, mask and clear behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data, REG_W = max(NUM_SRC, TO_W) |
| reg_rdata | output | REG_W | Read data for reg_addr, combinational |
| evt_in | input | NUM_SRC | Single-cycle event pulses, one per source |
| scl_in | input | 1 | Clock line level, already synchronized |
| scl_tick | input | 1 | One pulse per nominal serial-clock period |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_SRC = 6 and TO_W = 8, so the timeout source sits at bit 5. With that setting it can check the gap between an event source and the internal timeout source, and it can check the zero-padded upper read bits. Because the limit is 8 bits wide, the full 255-tick count at the reset value fits in a few hundred cycles, so the exact tick that fires at the upper limit is checked as well as small limits such as 3 and a limit of 0. The single register bus cannot write the enable and disable registers in the same cycle, so the disable-priority rule is covered by an assertion inside the mask register.

// File: rtl/imt_pkg.sv
// Shared definitions for the interrupt mask and timeout unit.
// Assumes a word-addressed register bus with a 3-bit address.
package imt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_MASK    = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_DISABLE = 3'd3,
        SEL_LIMIT   = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/imt_mask_reg.sv
// Per-source interrupt mask. Ones in set_bits turn bits on and ones in
// clr_bits turn them off; a clear wins over a set of the same bit.
// Assumes set_bits/clr_bits are already qualified by the bus decode.
module imt_mask_reg #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_bits,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] mask
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // One mask flop: clear has priority, otherwise set, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask[i] <= 1'b0;
            else if (clr_bits[i])
                mask[i] <= 1'b0;
            else if (set_bits[i])
                mask[i] <= 1'b1;
        end
    end

    // R2: a clear request leaves the bit off on the next cycle
    assert_clr_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|clr_bits)) |=> ((mask & $past(clr_bits)) == '0));

    // R1: a set request without a clear leaves the bit on
    assert_set_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|(set_bits & ~clr_bits)))
        |=> ((mask & $past(set_bits & ~clr_bits)) == $past(set_bits & ~clr_bits)));

    // R3: with no request the mask holds
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && set_bits == '0 && clr_bits == '0) |=> $stable(mask));

endmodule

// File: rtl/imt_status_reg.sv
// Sticky interrupt status. An event sets its bit; a clear request
// (write-one-to-clear) drops it unless an event lands in the same cycle.
// Assumes evt is a single-cycle pulse per occurrence.
module imt_status_reg #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] status
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // One status flop: event first, then clear, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[i] <= 1'b0;
            else if (evt[i])
                status[i] <= 1'b1;
            else if (clr_bits[i])
                status[i] <= 1'b0;
        end
    end

    // R4: every event leaves its bit set
    assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|evt)) |=> ((status & $past(evt)) == $past(evt)));

    // R5: a clear without a colliding event leaves the bit off
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|(clr_bits & ~evt))) |=> ((status & $past(clr_bits & ~evt)) == '0));

    // R5: no event and no clear means no change
    assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && evt == '0 && clr_bits == '0) |=> $stable(status));

endmodule

// File: rtl/imt_scl_watchdog.sv
// Clock-stretch watchdog with its own limit register. Counts scl_tick
// pulses while scl_in is low and pulses hit on the tick that reaches the
// limit, once per low period. A limit of zero switches it off.
// Assumes scl_in is synchronized to clk and scl_tick is one cycle wide.
module imt_scl_watchdog #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_in,
    input  logic            scl_tick,
    input  logic            lim_wr,
    input  logic [TO_W-1:0] lim_wdata,
    output logic [TO_W-1:0] limit,
    output logic            hit
);

    logic [TO_W-1:0] cnt;
    logic [TO_W:0]   cnt_nxt;
    logic            fired;
    logic            line_low;

    // Limit register, all ones out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit <= '1;
        else if (lim_wr)
            limit <= lim_wdata;
    end

    // Next count and the timeout decision for this cycle.
    always_comb begin
        line_low = !scl_in;
        cnt_nxt  = {1'b0, cnt} + 1'b1;
        hit      = line_low && scl_tick && !fired && (limit != '0)
                   && (cnt_nxt >= {1'b0, limit});
    end

    // Count ticks while low; restart on high; stop after firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (!line_low) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (scl_tick && !fired) begin
            cnt   <= cnt_nxt[TO_W-1:0];
            fired <= hit;
        end
    end

    // R9: a high line leaves the count at zero
    assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && scl_in) |=> (cnt == '0));

    // R9: never two timeouts back to back within one low period
    assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !scl_in) |=> !hit);

    // R8: a timeout only comes from a tick while the line is low
    assert_hit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (scl_tick && !scl_in));

endmodule

// File: rtl/irq_mask_timeout.sv
// Top of the interrupt mask and timeout unit. Decodes the register bus,
// instantiates mask, status and watchdog, muxes read data and forms the
// interrupt line. Source CMP_BIT is transfer completion and TO_BIT is the
// watchdog timeout. Assumes single-cycle writes and combinational reads.
module irq_mask_timeout
    import imt_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int TO_W    = 8,
    parameter int CMP_BIT = 0,
    parameter int TO_BIT  = NUM_SRC - 1,
    localparam int REG_W  = (NUM_SRC > TO_W) ? NUM_SRC : TO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               scl_in,
    input  logic               scl_tick,
    output logic               irq_out
);

    logic [NUM_SRC-1:0] en_set, dis_clr, st_clr, evt_all;
    logic [NUM_SRC-1:0] mask, status;
    logic [TO_W-1:0]    limit;
    logic               lim_wr, to_hit;
    reg_sel_e           sel;

    // Write decode into per-register strobes.
    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        en_set  = (reg_wr && sel == SEL_ENABLE)  ? reg_wdata[NUM_SRC-1:0] : '0;
        dis_clr = (reg_wr && sel == SEL_DISABLE) ? reg_wdata[NUM_SRC-1:0] : '0;
        st_clr  = (reg_wr && sel == SEL_STATUS)  ? reg_wdata[NUM_SRC-1:0] : '0;
        lim_wr  = reg_wr && sel == SEL_LIMIT;
    end

    // Merge the watchdog timeout into the event vector.
    always_comb begin
        evt_all         = evt_in;
        evt_all[TO_BIT] = evt_in[TO_BIT] | to_hit;
    end

    imt_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (en_set),
        .clr_bits (dis_clr),
        .mask     (mask)
    );

    imt_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_all),
        .clr_bits (st_clr),
        .status   (status)
    );

    imt_scl_watchdog #(.TO_W(TO_W)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .scl_tick  (scl_tick),
        .lim_wr    (lim_wr),
        .lim_wdata (reg_wdata[TO_W-1:0]),
        .limit     (limit),
        .hit       (to_hit)
    );

    // Read mux, zero-extended to the bus width.
    always_comb begin
        case (sel)
            SEL_STATUS: reg_rdata = REG_W'(status);
            SEL_MASK:   reg_rdata = REG_W'(mask);
            SEL_LIMIT:  reg_rdata = REG_W'(limit);
            default:    reg_rdata = '0;
        endcase
    end

    // Combined interrupt request.
    always_comb irq_out = |(status & mask);

    // R12: the completion and timeout sources are distinct and in range
    initial begin
        assert_src_index_R12: assert (CMP_BIT != TO_BIT && CMP_BIT < NUM_SRC && TO_BIT < NUM_SRC);
    end

    // R6: a request comes only from a set status bit
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status != '0));

endmodule

// File: tb/sim_irq_mask_timeout.sv
`timescale 1ns/1ps
module sim_irq_mask_timeout;

    localparam int NS   = 6;
    localparam int TW   = 8;
    localparam int RW   = 8;
    localparam int TOB  = NS - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic [NS-1:0] evt_in = '0;
    logic          scl_in = 1'b1;
    logic          scl_tick = 1'b0;
    logic          irq_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_mask_timeout #(.NUM_SRC(NS), .TO_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .scl_in(scl_in), .scl_tick(scl_tick), .irq_out(irq_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse_evt(input logic [NS-1:0] b);
        @(negedge clk);
        evt_in = b;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); scl_tick = 1'b1;
            @(negedge clk); scl_tick = 1'b0;
        end
    endtask

    task automatic scl_blip();
        @(negedge clk); scl_in = 1'b1;
        @(negedge clk); scl_in = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        @(negedge clk);
        rd(3'd0, v); chk("R11 status", v, 0);
        rd(3'd1, v); chk("R11 mask", v, 0);
        rd(3'd4, v); chk("R11 limit", v, 8'hFF);
        chk("R11 irq", int'(irq_out), 0);
    endtask

    task automatic t_mask();
        int v;
        wr(3'd2, 8'h05); rd(3'd1, v); chk("R1 enable sets", v, 8'h05);
        wr(3'd2, 8'h00); rd(3'd1, v); chk("R1 zero ignored", v, 8'h05);
        wr(3'd1, 8'h3F); rd(3'd1, v); chk("R3 mask read-only", v, 8'h05);
        wr(3'd3, 8'h01); rd(3'd1, v); chk("R2 disable clears", v, 8'h04);
        wr(3'd3, 8'h00); rd(3'd1, v); chk("R2 zero ignored", v, 8'h04);
        wr(3'd3, 8'h04); rd(3'd1, v); chk("R2 all off", v, 0);
    endtask

    task automatic t_status();
        int v;
        pulse_evt(6'b000100);
        rd(3'd0, v); chk("R4 masked event sets", v, 8'h04);
        chk("R6 masked no irq", int'(irq_out), 0);
        wr(3'd2, 8'h04); #1;
        chk("R6 irq after enable", int'(irq_out), 1);
        wr(3'd0, 8'h00); rd(3'd0, v); chk("R5 write 0 keeps", v, 8'h04);
        wr(3'd0, 8'h04); rd(3'd0, v); chk("R5 write 1 clears", v, 0);
        chk("R6 irq drops", int'(irq_out), 0);
        wr(3'd3, 8'h04);
    endtask

    task automatic t_collide();
        int v;
        pulse_evt(6'b001000);
        @(negedge clk);
        evt_in = 6'b001000; reg_addr = 3'd0; reg_wdata = 8'h08; reg_wr = 1'b1;
        @(negedge clk);
        evt_in = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(3'd0, v); chk("R5 event beats clear", v, 8'h08);
        wr(3'd0, 8'h08);
    endtask

    task automatic t_completion();
        int v;
        wr(3'd2, 8'h01);
        pulse_evt(6'b000001); #1;
        chk("R12 completion irq", int'(irq_out), 1);
        wr(3'd3, 8'h01); #1;
        chk("R12 completion masked", int'(irq_out), 0);
        rd(3'd0, v); chk("R12 completion status", v, 8'h01);
        wr(3'd0, 8'h01);
    endtask

    task automatic t_timeout();
        int v;
        wr(3'd4, 8'd3); rd(3'd4, v); chk("R7 limit readback", v, 3);
        wr(3'd2, 8'h20);
        @(negedge clk); scl_in = 1'b0;
        ticks(2); rd(3'd0, v); chk("R8 before limit", v, 0);
        ticks(1); rd(3'd0, v); chk("R8 at limit", v, 8'h20);
        chk("R12 timeout irq", int'(irq_out), 1);
        wr(3'd0, 8'h20);
        ticks(4); rd(3'd0, v); chk("R9 once per low", v, 0);
        scl_blip(); ticks(3); rd(3'd0, v); chk("R9 rearm after high", v, 8'h20);
        wr(3'd0, 8'h20);
        scl_blip(); ticks(2); scl_blip(); ticks(2);
        rd(3'd0, v); chk("R9 count restarts", v, 0);
        ticks(1); rd(3'd0, v); chk("R9 restarted count fires", v, 8'h20);
        wr(3'd0, 8'h20);
        @(negedge clk); scl_in = 1'b1;
        ticks(5); rd(3'd0, v); chk("R8 high ticks ignored", v, 0);
        wr(3'd3, 8'h20);
    endtask

    task automatic t_limit_edges();
        int v;
        wr(3'd4, 8'd0); rd(3'd4, v); chk("R7 limit zero", v, 0);
        @(negedge clk); scl_in = 1'b0;
        ticks(10); rd(3'd0, v); chk("R10 zero disables", v, 0);
        wr(3'd4, 8'hFF);
        scl_blip();
        ticks(254); rd(3'd0, v); chk("R8 254 ticks", v, 0);
        ticks(1); rd(3'd0, v); chk("R8 255th tick", v, 8'h20);
        @(negedge clk); scl_in = 1'b1;
        wr(3'd0, 8'h20);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_status();
        t_collide();
        t_completion();
        t_timeout();
        t_limit_edges();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule